// File: doc/BRIEF.md
# Padded 2D Tile Load Address Generator

This block expands one tile-load request into an ordered stream of scratchpad write commands. The tile is a rectangle of `rows` × `cols` elements. Row r of the tile starts at external memory element `dram_base + r * stride`, and each row holds `cols` consecutive elements. While the block walks the tile, it adds a configurable border of pad writes on each of the four sides. The scratchpad image is therefore `(pad_top + rows + pad_bottom)` entries tall and `(pad_left + cols + pad_right)` entries wide. It is written to consecutive scratchpad element addresses that start at `sram_base`.

Each command marks itself as either a fetch, which reads one external element and writes it to the scratchpad, or a pad write, which stores zero and needs no external access. A controller pulses `start` with the request fields present on the inputs. It then drains commands through a valid/ready handshake until `done` pulses. All addresses count elements, not bytes.

Top module: `padload_agen`

## Requirements
- R1: A `start` pulse while the block is idle captures every request field. Changes on the field inputs after that cycle do not alter the command stream.
- R2: A request with nonzero `rows` and `cols` yields exactly H × W commands, where H = pad_top + rows + pad_bottom and W = pad_left + cols + pad_right. The commands come in row-major order: rows run top to bottom, and within each row the left pad comes first, then the fetched elements, then the right pad.
- R3: A command at padded position (r, c) has `cmd_pad` = 1 unless pad_top ≤ r < pad_top + rows and pad_left ≤ c < pad_left + cols. A pad command drives `cmd_dram_addr` to zero.
- R4: A fetch command at (r, c) carries `cmd_dram_addr` = dram_base + (r − pad_top) × stride + (c − pad_left), modulo 2^DRAM_AW.
- R5: The n-th command (counting from 0) carries `cmd_sram_addr` = sram_base + n, modulo 2^SRAM_AW.
- R6: `cmd_last` is 1 on the final command of a request and 0 on all others.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields and `cmd_valid` hold their values into the next cycle. The stream advances only on an accepted command.
- R8: `busy` and `cmd_valid` are 1 from the cycle after an accepted start until the final command is accepted. In the next cycle both are 0 and `done` is 1 for exactly one cycle.
- R9: If `rows` or `cols` is zero, the block emits no command, `busy` stays 0, and `done` pulses in the cycle after `start`.
- R10: A `start` pulse while `busy` is 1 is ignored, and the running request continues unchanged.
- R11: After reset, `cmd_valid`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| cfg_dram_base | input | DRAM_AW | External element address of tile row 0 |
| cfg_sram_base | input | SRAM_AW | Scratchpad element address of the first command |
| cfg_rows | input | SIZE_W | Tile height |
| cfg_cols | input | SIZE_W | Tile width |
| cfg_stride | input | STRIDE_W | Element distance between tile rows |
| cfg_pad_top | input | PAD_W | Pad rows above the tile |
| cfg_pad_bottom | input | PAD_W | Pad rows below the tile |
| cfg_pad_left | input | PAD_W | Pad elements before each row |
| cfg_pad_right | input | PAD_W | Pad elements after each row |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_pad | output | 1 | 1 = pad write of zero, 0 = fetch |
| cmd_dram_addr | output | DRAM_AW | External element address (zero on pad) |
| cmd_sram_addr | output | SRAM_AW | Scratchpad element address |
| cmd_last | output | 1 | Final command of the request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench tries every combination of tile height and width from 0 to 3 against top and left borders of 0 to 2 and bottom and right borders of 0 to 1. This sweep separates the four border regions from the tile and exposes any off-by-one at either edge of the data window. Zero sizes exercise the empty path. Alternate runs throttle `cmd_ready` with a pseudo-random pattern to show that the stream advances only on acceptance. Other runs scramble the field inputs and pulse `start` mid-request, which shows that the fields are captured once. Dedicated cases cover the classic 4×4 tile from a 16-wide matrix with single-element borders, maximum 15-element borders, and address wrap in both address spaces with the largest stride.

// File: rtl/padload_pkg.sv
package padload_pkg;

    typedef enum logic [0:0] {
        RUN_IDLE = 1'b0,
        RUN_EMIT = 1'b1
    } run_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/padload_walk.sv
// Padded-image position walker: row-major scan with data window decode.
module padload_walk #(
    parameter int DIM_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             load,
    input  logic             step,
    input  logic [DIM_W-1:0] height,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] row_lo,
    input  logic [DIM_W-1:0] row_hi,
    input  logic [DIM_W-1:0] col_lo,
    input  logic [DIM_W-1:0] col_hi,
    output logic             in_data,
    output logic             row_data,
    output logic             row_end,
    output logic             is_last
);

    typedef struct packed {
        logic [DIM_W-1:0] y;
        logic [DIM_W-1:0] x;
    } pos_t;

    pos_t pos_q, pos_d;

    logic col_data;

    always_comb begin
        row_data = (pos_q.y >= row_lo) && (pos_q.y < row_hi);
        col_data = (pos_q.x >= col_lo) && (pos_q.x < col_hi);
        in_data  = row_data && col_data;
        row_end  = (pos_q.x == width - DIM_W'(1));
        is_last  = row_end && (pos_q.y == height - DIM_W'(1));
    end

    always_comb begin
        pos_d = pos_q;
        if (load) begin
            pos_d.y = '0;
            pos_d.x = '0;
        end else if (step) begin
            if (row_end) begin
                pos_d.x = '0;
                pos_d.y = pos_q.y + DIM_W'(1);
            end else begin
                pos_d.x = pos_q.x + DIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    // R2: the walker never leaves the padded image while emitting
    p_inside_image_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((pos_q.x < width) && (pos_q.y < height)));

    // R2: after a row-end acceptance the next command opens a fresh row
    p_row_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && row_end && !is_last) |=> (pos_q.x == '0));

endmodule

// File: rtl/padload_addr.sv
// Address tracker: external row base, column offset, scratchpad pointer.
module padload_addr #(
    parameter int DRAM_AW  = 32,
    parameter int SRAM_AW  = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic                in_data,
    input  logic                row_data,
    input  logic                row_end,
    input  logic [DRAM_AW-1:0]  load_dram_base,
    input  logic [SRAM_AW-1:0]  load_sram_base,
    input  logic [STRIDE_W-1:0] stride,
    output logic [DRAM_AW-1:0]  dram_addr,
    output logic [SRAM_AW-1:0]  sram_addr
);

    typedef struct packed {
        logic [DRAM_AW-1:0] row_base;
        logic [DRAM_AW-1:0] col;
        logic [SRAM_AW-1:0] sptr;
    } addr_t;

    addr_t a_q, a_d;

    always_comb begin
        a_d = a_q;
        if (load) begin
            a_d.row_base = load_dram_base;
            a_d.col      = '0;
            a_d.sptr     = load_sram_base;
        end else if (step) begin
            a_d.sptr = a_q.sptr + SRAM_AW'(1);
            if (row_end) begin
                a_d.col = '0;
                if (row_data) begin
                    a_d.row_base = a_q.row_base + DRAM_AW'(stride);
                end
            end else if (in_data) begin
                a_d.col = a_q.col + DRAM_AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    always_comb begin
        dram_addr = in_data ? (a_q.row_base + a_q.col) : '0;
        sram_addr = a_q.sptr;
    end

    // R5: every accepted command moves the scratchpad pointer by one element
    p_sram_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (sram_addr == $past(sram_addr) + SRAM_AW'(1)));

    // R4: consecutive fetches inside one row read consecutive elements
    p_dram_consecutive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_data && !row_end && !load) |=>
            (!in_data || (dram_addr == $past(dram_addr) + DRAM_AW'(1))));

endmodule

// File: rtl/padload_agen.sv
// Top: request capture, run control and command handshake.
module padload_agen #(
    parameter int DRAM_AW  = 32,
    parameter int SRAM_AW  = 16,
    parameter int SIZE_W   = 16,
    parameter int STRIDE_W = 16,
    parameter int PAD_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DRAM_AW-1:0]  cfg_dram_base,
    input  logic [SRAM_AW-1:0]  cfg_sram_base,
    input  logic [SIZE_W-1:0]   cfg_rows,
    input  logic [SIZE_W-1:0]   cfg_cols,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [PAD_W-1:0]    cfg_pad_top,
    input  logic [PAD_W-1:0]    cfg_pad_bottom,
    input  logic [PAD_W-1:0]    cfg_pad_left,
    input  logic [PAD_W-1:0]    cfg_pad_right,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic                cmd_pad,
    output logic [DRAM_AW-1:0]  cmd_dram_addr,
    output logic [SRAM_AW-1:0]  cmd_sram_addr,
    output logic                cmd_last,
    output logic                busy,
    output logic                done
);
    import padload_pkg::*;

    localparam int DIM_W = max_of(SIZE_W, PAD_W) + 2;

    typedef struct packed {
        run_state_e          st;
        logic                done;
        logic [SIZE_W-1:0]   rows;
        logic [SIZE_W-1:0]   cols;
        logic [STRIDE_W-1:0] stride;
        logic [PAD_W-1:0]    pad_t;
        logic [PAD_W-1:0]    pad_b;
        logic [PAD_W-1:0]    pad_l;
        logic [PAD_W-1:0]    pad_r;
    } ctl_t;

    ctl_t c_q, c_d;

    logic             load, step, req_empty;
    logic             in_data, row_data, row_end, is_last;
    logic [DIM_W-1:0] height, width, row_lo, row_hi, col_lo, col_hi;

    always_comb begin
        row_lo = DIM_W'(c_q.pad_t);
        row_hi = row_lo + DIM_W'(c_q.rows);
        height = row_hi + DIM_W'(c_q.pad_b);
        col_lo = DIM_W'(c_q.pad_l);
        col_hi = col_lo + DIM_W'(c_q.cols);
        width  = col_hi + DIM_W'(c_q.pad_r);
    end

    assign cmd_valid = (c_q.st == RUN_EMIT);
    assign busy      = (c_q.st == RUN_EMIT);
    assign done      = c_q.done;
    assign step      = cmd_valid && cmd_ready;
    assign req_empty = (cfg_rows == '0) || (cfg_cols == '0);

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load     = 1'b0;
        unique case (c_q.st)
            RUN_IDLE: begin
                if (start) begin
                    c_d.rows   = cfg_rows;
                    c_d.cols   = cfg_cols;
                    c_d.stride = cfg_stride;
                    c_d.pad_t  = cfg_pad_top;
                    c_d.pad_b  = cfg_pad_bottom;
                    c_d.pad_l  = cfg_pad_left;
                    c_d.pad_r  = cfg_pad_right;
                    if (req_empty) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.st = RUN_EMIT;
                        load   = 1'b1;
                    end
                end
            end
            RUN_EMIT: begin
                if (step && is_last) begin
                    c_d.st   = RUN_IDLE;
                    c_d.done = 1'b1;
                end
            end
            default: c_d.st = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= RUN_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    padload_walk #(
        .DIM_W (DIM_W)
    ) i_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (cmd_valid),
        .load     (load),
        .step     (step),
        .height   (height),
        .width    (width),
        .row_lo   (row_lo),
        .row_hi   (row_hi),
        .col_lo   (col_lo),
        .col_hi   (col_hi),
        .in_data  (in_data),
        .row_data (row_data),
        .row_end  (row_end),
        .is_last  (is_last)
    );

    padload_addr #(
        .DRAM_AW  (DRAM_AW),
        .SRAM_AW  (SRAM_AW),
        .STRIDE_W (STRIDE_W)
    ) i_addr (
        .clk            (clk),
        .rst_n          (rst_n),
        .load           (load),
        .step           (step),
        .in_data        (in_data),
        .row_data       (row_data),
        .row_end        (row_end),
        .load_dram_base (cfg_dram_base),
        .load_sram_base (cfg_sram_base),
        .stride         (c_q.stride),
        .dram_addr      (cmd_dram_addr),
        .sram_addr      (cmd_sram_addr)
    );

    assign cmd_pad  = !in_data;
    assign cmd_last = cmd_valid && is_last;

    // R7: a stalled command is held unchanged
    p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_pad) &&
            $stable(cmd_dram_addr) && $stable(cmd_sram_addr) && $stable(cmd_last)));

    // R8: accepting the last command ends the run with a done pulse
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_last) |=> (done && !cmd_valid && !busy));

    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an empty request completes without emitting
    p_empty_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_empty) |=> (done && !busy));

    // R10: start during a run does not disturb it
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(cmd_ready && cmd_last)) |=> (busy && !done));

    // R3: pad commands never carry an external address
    p_pad_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_pad) |-> (cmd_dram_addr == '0));

endmodule

// File: tb/test_padload_agen.sv
module test_padload_agen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_dram_base = '0;
    logic [15:0] cfg_sram_base = '0;
    logic [15:0] cfg_rows = '0, cfg_cols = '0, cfg_stride = '0;
    logic [3:0]  cfg_pad_top = '0, cfg_pad_bottom = '0, cfg_pad_left = '0, cfg_pad_right = '0;
    logic        cmd_valid, cmd_ready = 1'b0, cmd_pad, cmd_last, busy, done;
    logic [31:0] cmd_dram_addr;
    logic [15:0] cmd_sram_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk; // 50 MHz

    padload_agen i_padload_agen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_dram_base(cfg_dram_base), .cfg_sram_base(cfg_sram_base),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_stride(cfg_stride),
        .cfg_pad_top(cfg_pad_top), .cfg_pad_bottom(cfg_pad_bottom),
        .cfg_pad_left(cfg_pad_left), .cfg_pad_right(cfg_pad_right),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_pad(cmd_pad),
        .cmd_dram_addr(cmd_dram_addr), .cmd_sram_addr(cmd_sram_addr),
        .cmd_last(cmd_last), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input int yp0, input int yp1, input int xp0, input int xp1,
                           input int ys, input int xs, input int stride,
                           input longint dbase, input int sbase,
                           input bit throttle, input bit busy_start);
        int h = yp0 + ys + yp1;
        int w = xp0 + xs + xp1;
        int total = (ys == 0 || xs == 0) ? 0 : h * w;
        int idx = 0;
        @(negedge clk);
        cfg_dram_base = dbase[31:0];  cfg_sram_base = sbase[15:0];
        cfg_rows = ys[15:0];          cfg_cols = xs[15:0];
        cfg_stride = stride[15:0];
        cfg_pad_top = yp0[3:0];       cfg_pad_bottom = yp1[3:0];
        cfg_pad_left = xp0[3:0];      cfg_pad_right = xp1[3:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: scramble the field inputs after capture
        cfg_dram_base = ~cfg_dram_base; cfg_sram_base = ~cfg_sram_base;
        cfg_rows = cfg_rows ^ 16'h0005; cfg_cols = cfg_cols ^ 16'h0003;
        cfg_stride = ~cfg_stride;
        cfg_pad_top = ~cfg_pad_top;   cfg_pad_bottom = ~cfg_pad_bottom;
        cfg_pad_left = ~cfg_pad_left; cfg_pad_right = ~cfg_pad_right;
        if (total == 0) begin
            chk(done && !cmd_valid && !busy, "R9", "empty done/valid/busy",
                {done, cmd_valid, busy}, 3'b100);
            @(negedge clk);
            chk(!done, "R8", "done width", done, 0);
            return;
        end
        while (idx < total) begin
            bit rdy;
            if (throttle) begin
                rdy = lfsr[0] | lfsr[3];
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            end else begin
                rdy = 1'b1;
            end
            cmd_ready = rdy;
            start = busy_start && (idx == 1) && (total > 2); // R10
            if (!(cmd_valid && busy)) begin
                chk(0, "R8", "valid/busy during run", {cmd_valid, busy}, 2'b11);
            end
            if (rdy) begin
                int r = idx / w;
                int c = idx % w;
                bit epad = !(r >= yp0 && r < yp0 + ys && c >= xp0 && c < xp0 + xs);
                longint edram = epad ? 0 :
                    (dbase + longint'(r - yp0) * stride + (c - xp0)) & 64'hFFFF_FFFF;
                longint esram = (sbase + idx) & 64'hFFFF;
                chk(cmd_pad == epad, "R3", "pad flag", cmd_pad, epad);
                chk(cmd_dram_addr == edram[31:0], epad ? "R3" : "R4", "dram addr",
                    cmd_dram_addr, edram);
                chk(cmd_sram_addr == esram[15:0], "R5", "sram addr", cmd_sram_addr, esram);
                chk(cmd_last == (idx == total - 1), "R6", "last flag",
                    cmd_last, (idx == total - 1));
                idx++;
            end
            @(negedge clk);
            start = 1'b0;
        end
        cmd_ready = 1'b0;
        // R2: exactly H*W commands, then the run closes
        chk(done && !cmd_valid && !busy, "R2", "end after H*W commands",
            {done, cmd_valid, busy}, 3'b100);
        @(negedge clk);
        chk(!done, "R8", "done width", done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int k = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!cmd_valid && !busy && !done, "R11", "reset outputs",
            {cmd_valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid && !busy && !done, "R11", "idle after reset",
            {cmd_valid, busy, done}, 0);

        // R2, R3, R4: the 4x4 tile from a 16-wide matrix with unit borders (6x6)
        run_one(1, 1, 1, 1, 4, 4, 16, 32'h0000_1000, 16'h0040, 1'b0, 1'b0);

        // Sweep of sizes and borders
        for (int ys = 0; ys < 4; ys++)
            for (int xs = 0; xs < 4; xs++)
                for (int yp0 = 0; yp0 < 3; yp0++)
                    for (int xp0 = 0; xp0 < 3; xp0++)
                        for (int yp1 = 0; yp1 < 2; yp1++)
                            for (int xp1 = 0; xp1 < 2; xp1++) begin
                                run_one(yp0, yp1, xp0, xp1, ys, xs, xs + 3 + (k % 5),
                                        longint'(k) * 37, (k * 11) & 16'hFFFF,
                                        k[0], (k % 3) == 0);
                                k++;
                            end

        // R4, R5: wrap in both address spaces with the widest stride
        run_one(1, 2, 2, 1, 3, 2, 16'hFFFF, 32'hFFFF_FFF0, 16'hFFF8, 1'b1, 1'b1);
        // R2: largest borders around a single element
        run_one(15, 15, 15, 15, 1, 1, 1, 32'h0000_0100, 16'h0000, 1'b0, 1'b0);
        // R9: zero-size with large borders still emits nothing
        run_one(15, 15, 15, 15, 0, 7, 9, 32'h0000_0200, 16'h0010, 1'b0, 1'b0);
        // R1, R10: throttled run with a mid-run start
        run_one(2, 0, 0, 2, 3, 3, 40, 32'h0000_5000, 16'h0100, 1'b1, 1'b1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule